// File: doc/BRIEF.md
# Paired-Page Associative Address Translator

This block turns a 32-bit virtual address into a physical address through a small, fully associative buffer of translation entries. Each entry holds one key: a virtual pair number, a page-size mask, an address-space tag and a shared flag. The key covers two neighbouring virtual pages. The entry also holds two independent result halves, one for the even page and one for the odd page. Each half carries a frame number, a valid bit, a write-permit bit, a 3-bit cache attribute and a global bit. All keys are compared against the presented address in the same cycle. One address bit above the unmasked page offset picks the half.

The lookup path is purely combinational. It returns the physical address, the cache attribute and a cacheable indication, plus one of four fault flags: miss, invalid page, write to a protected page, or machine check on a multiple hit. A miss, an invalid page or a write to a protected page loads two registers on the next clock edge. One holds the offending virtual address. The other holds its pair number together with the address-space tag. Software installs entries through an indexed write port. Refill policy, page-table walking and cache handling lie outside this block.

Top module: `ptx_translator`

## Requirements
- R1: When a translation succeeds, pa_o takes its bits below the page size from va_i. Its higher bits come from the selected half's frame number placed from bit 12 upward. The page size is 4 KB << (number of ones in the entry mask).
- R2: The entry mask has n low ones. Address bit 12+n selects the half: 0 picks the even half (wr_even_i), 1 picks the odd half (wr_odd_i). With mask 0 this is bit 12; with mask 0xFFF it is bit 24.
- R3: Mask bit k removes virtual address bit 13+k from the key compare. Key bits va_i[31:13] are compared against the stored pair number. Legal masks are 0x000, 0x003, 0x00F and so on up to 0xFFF, giving 4 KB to 16 MB pages.
- R4: An entry matches only if its tag equals asid_i. The exception is when both of its halves have the global bit set (the AND of the two bits); then the tag is ignored.
- R5: A valid lookup (lkup_vld_i=1) that matches no entry raises refill_o.
- R6: A matched half with valid=0 raises invalid_o. A store (store_i=1) to a valid half with write-permit=0 raises modify_o. The order of precedence is refill, then invalid, then modify. At most one fault flag is high, and a store to a writable half translates.
- R7: When refill_o, invalid_o or modify_o is high, bad_va_o takes va_i at the next rising clock and entry_hi_o takes {va_i[31:13], asid_i}. In all other cycles both hold their value.
- R8: cattr_o passes the selected half's 3-bit attribute through unchanged on success. cacheable_o is 1 only for attribute value 3.
- R9: If two or more entries match, mcheck_o is raised and no other flag is raised. pa_o, cattr_o and cacheable_o are 0, and the capture registers do not load.
- R10: Reset clears bad_va_o and entry_hi_o. It gives entry i the pair number 0x7FFFF-i, mask 0, tag 0 and all half bits 0, so every lookup after reset ends in refill or invalid.
- R11: A write with wr_en_i=1 replaces entry wr_idx_i at the clock edge. Half layout: bit 0 global, bit 1 valid, bit 2 write-permit, bits 5:3 attribute, bits 25:6 frame number. Other entries are unchanged.
- R12: With lkup_vld_i=0, all flags and pa_o, cattr_o and cacheable_o are 0, and the capture registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkup_vld_i | input | 1 | Lookup request this cycle |
| va_i | input | 32 | Virtual address |
| asid_i | input | 8 | Current address-space tag |
| store_i | input | 1 | Access is a store |
| wr_en_i | input | 1 | Install entry |
| wr_idx_i | input | 5 | Entry index to install |
| wr_vpn2_i | input | 19 | Virtual pair number |
| wr_mask_i | input | 12 | Page-size mask |
| wr_asid_i | input | 8 | Entry tag |
| wr_even_i | input | 26 | Even half fields |
| wr_odd_i | input | 26 | Odd half fields |
| pa_o | output | 32 | Physical address |
| cattr_o | output | 3 | Cache attribute |
| cacheable_o | output | 1 | Attribute equals 3 |
| refill_o | output | 1 | No entry matched |
| invalid_o | output | 1 | Selected half invalid |
| modify_o | output | 1 | Store to protected half |
| mcheck_o | output | 1 | Multiple entries matched |
| bad_va_o | output | 32 | Last faulting address |
| entry_hi_o | output | 27 | Last faulting pair number and tag |

## Verification
A corrupted entry or a wrong half-select shows up at once, in the same cycle as the lookup. It appears as a wrong pa_o upper field, a swapped attribute or a fault flag that should not be there. A key-compare error turns a hit into a refill, or two hits into a machine check. Capture-register faults appear one clock after the faulting lookup, as a wrong or missing update of bad_va_o and entry_hi_o. They also show as a spurious update on a lookup that should leave the registers alone.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  parameter int ADDR_W = 32;
  parameter int PG_W   = 12;
  parameter int ASID_W = 8;
  parameter int MASK_W = 12;
  localparam int VPN2_W = ADDR_W - PG_W - 1;
  localparam int PFN_W  = ADDR_W - PG_W;
  localparam int HI_W   = VPN2_W + ASID_W;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cattr;
    logic             wr_ok;
    logic             vld;
    logic             glb;
  } half_t;

  localparam int HALF_W = $bits(half_t);

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [MASK_W-1:0] mask;
    logic [ASID_W-1:0] asid;
    half_t             odd;
    half_t             even;
  } entry_t;
endpackage

// File: rtl/ptx_entry_store.sv
module ptx_entry_store
  import ptx_pkg::*;
#(
  parameter int  NUM_ENTRIES = 32,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_entry_i,
  output entry_t           entries_o [NUM_ENTRIES]
);
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    // distinct reset keys keep the array free of multi-hits
    localparam logic [VPN2_W-1:0] RST_VPN2 = {VPN2_W{1'b1}} - VPN2_W'(i);
    entry_t ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '{vpn2: RST_VPN2, mask: '0, asid: '0, odd: '0, even: '0};
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        ent_q <= wr_entry_i;
      end
    end

    assign entries_o[i] = ent_q;
  end
endmodule

// File: rtl/ptx_match.sv
module ptx_match
  import ptx_pkg::*;
(
  input  entry_t              entry_i,
  input  logic [ADDR_W-1:0]   va_i,
  input  logic [ASID_W-1:0]   asid_i,
  output logic                hit_o,
  output half_t               half_o,
  output logic [ADDR_W-1:0]   offs_o
);
  logic [VPN2_W-1:0] cmp_mask;
  logic              key_hit;
  logic              glob;
  logic [MASK_W:0]   ext;
  logic [MASK_W:0]   sel_oh;
  logic              odd_sel;

  assign cmp_mask = ~{{(VPN2_W-MASK_W){1'b0}}, entry_i.mask};
  assign key_hit  = ((va_i[ADDR_W-1:PG_W+1] ^ entry_i.vpn2) & cmp_mask) == '0;
  assign glob     = entry_i.even.glb & entry_i.odd.glb;
  assign hit_o    = key_hit && (glob || (entry_i.asid == asid_i));

  // lowest zero of {0,mask} marks the half-select bit
  assign ext     = {1'b0, entry_i.mask};
  assign sel_oh  = ~ext & (ext + 1'b1);
  assign odd_sel = |(va_i[PG_W+MASK_W:PG_W] & sel_oh);
  assign half_o  = odd_sel ? entry_i.odd : entry_i.even;
  assign offs_o  = {{(ADDR_W-PG_W-MASK_W){1'b0}}, entry_i.mask, {PG_W{1'b1}}};
endmodule

// File: rtl/ptx_resolve.sv
module ptx_resolve
  import ptx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32
) (
  input  logic                lkup_vld_i,
  input  logic                store_i,
  input  logic [ADDR_W-1:0]   va_i,
  input  logic [NUM_ENTRIES-1:0] hit_i,
  input  half_t               half_i [NUM_ENTRIES],
  input  logic [ADDR_W-1:0]   offs_i [NUM_ENTRIES],
  output logic [ADDR_W-1:0]   pa_o,
  output logic [2:0]          cattr_o,
  output logic                cacheable_o,
  output logic                refill_o,
  output logic                invalid_o,
  output logic                modify_o,
  output logic                mcheck_o
);
  localparam logic [2:0] CATTR_CACHED = 3'd3;

  logic [HALF_W-1:0] half_bits;
  logic [ADDR_W-1:0] offs;
  logic              seen, multi;
  half_t             sel;
  logic              single, ok;

  always_comb begin
    half_bits = '0;
    offs      = '0;
    seen      = 1'b0;
    multi     = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      multi     = multi | (seen & hit_i[i]);
      seen      = seen | hit_i[i];
      half_bits = half_bits | ({HALF_W{hit_i[i]}} & half_i[i]);
      offs      = offs | ({ADDR_W{hit_i[i]}} & offs_i[i]);
    end
  end

  assign sel    = half_t'(half_bits);
  assign single = lkup_vld_i & seen & ~multi;

  assign mcheck_o  = lkup_vld_i & multi;
  assign refill_o  = lkup_vld_i & ~seen;
  assign invalid_o = single & ~sel.vld;
  assign modify_o  = single & sel.vld & store_i & ~sel.wr_ok;
  assign ok        = single & sel.vld & ~(store_i & ~sel.wr_ok);

  assign pa_o        = ok ? (({sel.pfn, {PG_W{1'b0}}} & ~offs) | (va_i & offs)) : '0;
  assign cattr_o     = ok ? sel.cattr : 3'd0;
  assign cacheable_o = ok && (sel.cattr == CATTR_CACHED);
endmodule

// File: rtl/ptx_translator.sv
module ptx_translator
  import ptx_pkg::*;
#(
  parameter int  NUM_ENTRIES = 32,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkup_vld_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              store_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN2_W-1:0] wr_vpn2_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [HALF_W-1:0] wr_even_i,
  input  logic [HALF_W-1:0] wr_odd_i,
  output logic [ADDR_W-1:0] pa_o,
  output logic [2:0]        cattr_o,
  output logic              cacheable_o,
  output logic              refill_o,
  output logic              invalid_o,
  output logic              modify_o,
  output logic              mcheck_o,
  output logic [ADDR_W-1:0] bad_va_o,
  output logic [HI_W-1:0]   entry_hi_o
);
  entry_t               wr_entry;
  entry_t               entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit;
  half_t                halves [NUM_ENTRIES];
  logic [ADDR_W-1:0]    offs [NUM_ENTRIES];
  logic                 exc;
  logic [ADDR_W-1:0]    bad_va_q;
  logic [HI_W-1:0]      hi_q;

  assign wr_entry = '{vpn2: wr_vpn2_i, mask: wr_mask_i, asid: wr_asid_i,
                      odd: half_t'(wr_odd_i), even: half_t'(wr_even_i)};

  ptx_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) store_i0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .entries_o  (entries)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    ptx_match match_i (
      .entry_i (entries[i]),
      .va_i    (va_i),
      .asid_i  (asid_i),
      .hit_o   (hit[i]),
      .half_o  (halves[i]),
      .offs_o  (offs[i])
    );
  end

  ptx_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) resolve_i (
    .lkup_vld_i  (lkup_vld_i),
    .store_i     (store_i),
    .va_i        (va_i),
    .hit_i       (hit),
    .half_i      (halves),
    .offs_i      (offs),
    .pa_o        (pa_o),
    .cattr_o     (cattr_o),
    .cacheable_o (cacheable_o),
    .refill_o    (refill_o),
    .invalid_o   (invalid_o),
    .modify_o    (modify_o),
    .mcheck_o    (mcheck_o)
  );

  assign exc = refill_o | invalid_o | modify_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_va_q <= '0;
      hi_q     <= '0;
    end else if (exc) begin
      bad_va_q <= va_i;
      hi_q     <= {va_i[ADDR_W-1:PG_W+1], asid_i};
    end
  end

  assign bad_va_o   = bad_va_q;
  assign entry_hi_o = hi_q;
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker
  import ptx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkup_vld_i,
  input logic [ADDR_W-1:0] va_i,
  input logic [ASID_W-1:0] asid_i,
  input logic              store_i,
  input logic [ADDR_W-1:0] pa_o,
  input logic              refill_o,
  input logic              invalid_o,
  input logic              modify_o,
  input logic              mcheck_o,
  input logic [ADDR_W-1:0] bad_va_o,
  input logic [HI_W-1:0]   entry_hi_o
);
  logic any_flag;
  assign any_flag = refill_o | invalid_o | modify_o | mcheck_o;

  p_one_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({refill_o, invalid_o, modify_o, mcheck_o}));

  p_modify_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modify_o |-> store_i);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkup_vld_i |-> (!any_flag && pa_o == '0));

  p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkup_vld_i && !any_flag) |-> (pa_o[PG_W-1:0] == va_i[PG_W-1:0]));

  p_mcheck_suppress_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcheck_o |-> (pa_o == '0));

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_o || invalid_o || modify_o) |=>
      (bad_va_o == $past(va_i) &&
       entry_hi_o == {$past(va_i[ADDR_W-1:PG_W+1]), $past(asid_i)}));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refill_o || invalid_o || modify_o) |=>
      ($stable(bad_va_o) && $stable(entry_hi_o)));
endmodule

bind ptx_translator ptx_checker chk_i (.*);

// File: tb/ptx_translator_tb_top.sv
module ptx_translator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkup_vld_i = 1'b0;
  logic [31:0] va_i = '0;
  logic [7:0]  asid_i = '0;
  logic        store_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [18:0] wr_vpn2_i = '0;
  logic [11:0] wr_mask_i = '0;
  logic [7:0]  wr_asid_i = '0;
  logic [25:0] wr_even_i = '0;
  logic [25:0] wr_odd_i = '0;
  logic [31:0] pa_o;
  logic [2:0]  cattr_o;
  logic        cacheable_o, refill_o, invalid_o, modify_o, mcheck_o;
  logic [31:0] bad_va_o;
  logic [26:0] entry_hi_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_bad = '0;
  logic [26:0] exp_hi = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ptx_translator dut_i (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        st;
    logic [31:0] pa;
    logic [2:0]  c;
    logic [3:0]  fl;   // {refill, invalid, modify, mcheck}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h00020ABC, 8'd5, 1'b0, 32'h11111ABC, 3'd3, 4'b0000, 8'd1},  // R1 even half
    '{32'h00021ABC, 8'd5, 1'b0, 32'h22222ABC, 3'd2, 4'b0000, 8'd2},  // R2 odd half
    '{32'h00021ABC, 8'd5, 1'b1, 32'h0,        3'd0, 4'b0010, 8'd6},  // R6 modify
    '{32'h00020ABC, 8'd5, 1'b1, 32'h11111ABC, 3'd3, 4'b0000, 8'd6},  // R6 writable store
    '{32'h00020ABC, 8'd6, 1'b0, 32'h0,        3'd0, 4'b1000, 8'd4},  // R4 tag mismatch
    '{32'h00203456, 8'd9, 1'b0, 32'h30003456, 3'd3, 4'b0000, 8'd3},  // R3 16 KB global
    '{32'h00207000, 8'd9, 1'b0, 32'h0,        3'd0, 4'b0100, 8'd6},  // R6 invalid
    '{32'h00207000, 8'd9, 1'b1, 32'h0,        3'd0, 4'b0100, 8'd6},  // R6 invalid beats modify
    '{32'h00208000, 8'd7, 1'b0, 32'h0,        3'd0, 4'b1000, 8'd3},  // R3 outside region
    '{32'h00400010, 8'd6, 1'b0, 32'h0,        3'd0, 4'b1000, 8'd4},  // R4 global AND
    '{32'h00400010, 8'd5, 1'b0, 32'h50000010, 3'd4, 4'b0000, 8'd8},  // R8 attr 4
    '{32'h81123456, 8'd1, 1'b0, 32'h90123456, 3'd3, 4'b0000, 8'd3},  // R3 16 MB odd
    '{32'h80ABCDEF, 8'd2, 1'b1, 32'h80ABCDEF, 3'd3, 4'b0000, 8'd2},  // R2 16 MB even
    '{32'h00023000, 8'd5, 1'b0, 32'h0,        3'd0, 4'b1000, 8'd5}   // R5 miss
  };

  function automatic logic [25:0] half(input logic [19:0] pfn, input logic [2:0] c,
                                       input logic d, input logic v, input logic g);
    return {pfn, c, d, v, g};
  endfunction

  function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endfunction

  task automatic install(input logic [4:0] idx, input logic [18:0] vpn2, input logic [11:0] mask,
                         input logic [7:0] asid, input logic [25:0] ev, input logic [25:0] od);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_vpn2_i = vpn2; wr_mask_i = mask;
    wr_asid_i = asid; wr_even_i = ev; wr_odd_i = od;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic look(input string tag, input logic vld, input logic [31:0] va, input logic [7:0] asid,
                      input logic st, input logic [31:0] epa, input logic [2:0] ec, input logic [3:0] efl);
    @(negedge clk_i);
    lkup_vld_i = vld; va_i = va; asid_i = asid; store_i = st;
    #2;
    chk(tag, {28'd0, refill_o, invalid_o, modify_o, mcheck_o}, {28'd0, efl});
    chk(tag, pa_o, epa);
    chk(tag, {29'd0, cattr_o}, {29'd0, ec});
    chk(tag, {31'd0, cacheable_o}, {31'd0, (efl == 4'b0000 && vld && ec == 3'd3)});
    if (vld && efl[3:1] != 3'b000) begin
      exp_bad = va;
      exp_hi  = {va[31:13], asid};
    end
    @(posedge clk_i);
    #1;
    chk({tag, " R7 bad"}, bad_va_o, exp_bad);
    chk({tag, " R7 hi"}, {5'd0, entry_hi_o}, {5'd0, exp_hi});
    lkup_vld_i = 1'b0; store_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 reset bad_va", bad_va_o, 32'h0);
    chk("R10 reset entry_hi", {5'd0, entry_hi_o}, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R10 no translation from reset state
    look("R10 miss", 1'b1, 32'h00000000, 8'd0, 1'b0, 32'h0, 3'd0, 4'b1000);
    look("R10 invalid", 1'b1, 32'hFFFFE000, 8'd0, 1'b0, 32'h0, 3'd0, 4'b0100);

    // R11 install entries
    install(5'd0, 19'h00010, 12'h000, 8'd5,
            half(20'h11111, 3'd3, 1'b1, 1'b1, 1'b0), half(20'h22222, 3'd2, 1'b0, 1'b1, 1'b0));
    install(5'd1, 19'h00100, 12'h003, 8'd7,
            half(20'h30000, 3'd3, 1'b1, 1'b1, 1'b1), half(20'h40000, 3'd5, 1'b0, 1'b0, 1'b1));
    install(5'd2, 19'h00200, 12'h000, 8'd5,
            half(20'h50000, 3'd4, 1'b1, 1'b1, 1'b1), half(20'h00000, 3'd0, 1'b0, 1'b0, 1'b0));
    install(5'd31, 19'h40000, 12'hFFF, 8'd0,
            half(20'h80000, 3'd3, 1'b1, 1'b1, 1'b1), half(20'h90000, 3'd3, 1'b1, 1'b1, 1'b1));

    for (int i = 0; i < NV; i++) begin
      look($sformatf("R%0d vec%0d", VECS[i].req, i), 1'b1, VECS[i].va, VECS[i].asid,
           VECS[i].st, VECS[i].pa, VECS[i].c, VECS[i].fl);
    end

    // R12 idle lookup is silent and leaves capture registers
    look("R12 idle", 1'b0, 32'h00FF0000, 8'd3, 1'b1, 32'h0, 3'd0, 4'b0000);

    // R9 duplicate key
    install(5'd3, 19'h00010, 12'h000, 8'd5,
            half(20'h77777, 3'd3, 1'b1, 1'b1, 1'b0), half(20'h77777, 3'd3, 1'b1, 1'b1, 1'b0));
    look("R9 multi", 1'b1, 32'h00020ABC, 8'd5, 1'b0, 32'h0, 3'd0, 4'b0001);

    // R11 overwrite removes the duplicate
    install(5'd3, 19'h00300, 12'h000, 8'd5,
            half(20'h77777, 3'd3, 1'b1, 1'b1, 1'b0), half(20'h77777, 3'd3, 1'b1, 1'b1, 1'b0));
    look("R11 rewrite", 1'b1, 32'h00020ABC, 8'd5, 1'b0, 32'h11111ABC, 3'd3, 4'b0000);
    look("R11 new entry", 1'b1, 32'h00601004, 8'd5, 1'b0, 32'h77777004, 3'd3, 4'b0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule